// File: doc/BRIEF.md
# SPI Master with Programmable Select Timing

This block is a single-select SPI master. Software configures it through a small register write port. A write to the transmit register sends one word. That write carries the word's data and a hold flag, and it starts the transfer in the same cycle. The chip-select pin has two programmable levels: one for idle and one for active. This lets the same block drive either an active-low or an active-high slave.

Two delays in module-clock cycles shape the select line. A lead delay sits between select assertion and the first serial clock edge. A trail delay sits between the last serial clock edge and select release. The hold flag lets a multi-word frame keep the slave selected. When a word is written with hold set, the select stays active after that word ends and its trail delay is skipped. The next word then skips its lead delay and starts shifting almost at once. Because of this, select timing depends on the hold flag of the previous word as well as the current one.

The serial clock rate comes from a prescaler. The frame format sets clock polarity, clock phase, bit order and word length. Received bits are returned in `rx_data`, and a one-cycle `done` pulse marks the end of each word. The register port is a plain control interface with no back-pressure. A write that arrives while `busy` is high is dropped, so software must wait for `busy` to fall.

Top module: `spi_cs_master`

## Requirements
- R1: While no word is in progress and no hold is pending, `cs` equals the idle-level bit (select register, address 2, bit 0). After reset this bit is 1, so `cs` is high.
- R2: From the cycle after a transmit write is accepted until the select is released, `cs` equals the active-level bit (select register, bit 8).
- R3: A word written with the hold flag (transmit register, address 3, bit 28) set leaves `cs` at its active level after it ends. `cs` stays there until a later word written with hold clear completes.
- R4: The transmit write is accepted at clock edge E0, and `cs` goes active at that edge. The first SCLK edge occurs at edge E0+D+1. D is the lead delay (delay register, address 1, bits 31:24) when the previous word had hold clear, and 0 when it had hold set.
- R5: When a word has hold clear, `cs` returns to its idle level T+1 module cycles after that word's last SCLK edge. T is the trail delay (delay register, bits 23:16). When hold is set, `cs` is not released.
- R6: Consecutive SCLK edges within a word are prescale+1 module cycles apart. Prescale is the format register (address 0) bits 7:0. The lead and trail delays count module cycles regardless of prescale.
- R7: Each word produces exactly 2L SCLK edges. Outside a word, SCLK rests at the polarity bit (format bit 16).
- R8: With the phase bit (format bit 17) clear, data is sampled on SCLK edges 0, 2, 4 and so on, counting from 0. With the phase bit set, data is sampled on edges 1, 3, 5 and so on. MOSI holds the outgoing bit at every sampling edge, and MISO is captured on those edges into `rx_data`.
- R9: The word length L equals format bits 11:8 plus 1. Data goes out and comes in MSB-first, from data bit L-1 (transmit bits 15:0) down to bit 0. If format bit 18 is set, the order is LSB-first, from bit 0 up. Bits of `rx_data` above L-1 read 0.
- R10: `busy` rises the cycle after an accepted transmit write. It falls at the release edge of R5, or at the last SCLK edge when hold is set. `done` is high for exactly that one cycle when `busy` falls.
- R11: Any write to any register while `busy` is high is ignored. It starts no word and changes no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 format, 1 delays, 2 select levels, 3 transmit |
| wr_data | input | 32 | Register write data |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rx_data | output | DATA_W | Bits received during the last word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs | output | 1 | Chip select |

## Verification
The main stimulus is a sweep over every combination of polarity, phase, bit order, three word lengths (1, 5 and 16), two prescale values, and zero or non-zero lead and trail delays. Each word uses distinct transmit and receive patterns. This separates a swapped sampling edge from a swapped bit order, and a length error from a spacing error. A hold-flag sequence (set, set, clear, then a fresh word) separates lead-delay skipping from lead-delay use, and shows whether the select drops between held words. Writes to the transmit, delay and format registers during a busy word are checked against later words' edge timing and data, which would expose any write that leaked through. The select levels alternate between active-low and active-high across the sweep.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_SHIFT, SQ_TRAIL} sq_state_e;

  localparam logic [1:0] RA_FORMAT = 2'd0;
  localparam logic [1:0] RA_DELAY  = 2'd1;
  localparam logic [1:0] RA_SELECT = 2'd2;
  localparam logic [1:0] RA_TXWORD = 2'd3;

  localparam int FB_LEN   = 8;
  localparam int FB_CPOL  = 16;
  localparam int FB_CPHA  = 17;
  localparam int FB_LSB   = 18;
  localparam int DB_LEAD  = 31;
  localparam int DB_TRAIL = 23;
  localparam int SB_IDLE  = 0;
  localparam int SB_ACT   = 8;
  localparam int TB_HOLD  = 28;
endpackage

// File: rtl/spi_cs_tick.sv
module spi_cs_tick #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;

  assign tick = run && (div_q == prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      div_q <= '0;
    else if (!run || div_q == prescale) div_q <= '0;
    else                             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/spi_cs_shift.sv
module spi_cs_shift #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              edge_stb,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic              last_edge
);
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [LEN_W:0]    ecnt_q;
  logic [LEN_W-1:0]  bit_q, pos;
  logic              tgl_q, leading, sample_now, advance;

  always_comb begin
    pos        = lsb_first ? bit_q : (len_m1 - bit_q);
    leading    = ~ecnt_q[0];
    sample_now = edge_stb && (leading ^ cpha);
    advance    = edge_stb && (cpha ? (leading && ecnt_q != '0) : !leading);
    last_edge  = edge_stb && (ecnt_q == {len_m1, 1'b1});
    mosi       = (int'(pos) < DATA_W) ? tx_q[pos] : 1'b0;
  end

  assign sclk    = cpol ^ tgl_q;
  assign rx_word = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      ecnt_q <= '0;
      bit_q  <= '0;
      tgl_q  <= 1'b0;
    end else if (load) begin
      tx_q   <= load_word;
      rx_q   <= '0;
      ecnt_q <= '0;
      bit_q  <= '0;
      tgl_q  <= 1'b0;
    end else if (edge_stb) begin
      tgl_q  <= ~tgl_q;
      ecnt_q <= ecnt_q + 1'b1;
      if (sample_now && int'(pos) < DATA_W) rx_q[pos] <= miso;
      if (advance) bit_q <= bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hold_in,
  input  logic [DLY_W-1:0] lead_dly,
  input  logic [DLY_W-1:0] trail_dly,
  input  logic             last_edge,
  output logic             busy,
  output logic             done,
  output logic             cs_on,
  output logic             first_edge,
  output logic             run,
  output logic             held
);
  sq_state_e        state_q;
  logic [DLY_W-1:0] cnt_q;
  logic             cur_hold_q, held_q, cs_on_q, done_q;

  assign busy       = (state_q != SQ_IDLE);
  assign first_edge = (state_q == SQ_LEAD) && (cnt_q == '0);
  assign run        = (state_q == SQ_SHIFT);
  assign held       = held_q;
  assign cs_on      = cs_on_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cnt_q      <= '0;
      cur_hold_q <= 1'b0;
      held_q     <= 1'b0;
      cs_on_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: if (start) begin
          cur_hold_q <= hold_in;
          cnt_q      <= held_q ? '0 : lead_dly;
          cs_on_q    <= 1'b1;
          state_q    <= SQ_LEAD;
        end
        SQ_LEAD: begin
          if (cnt_q == '0) state_q <= SQ_SHIFT;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        SQ_SHIFT: if (last_edge) begin
          held_q <= cur_hold_q;
          if (cur_hold_q) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q   <= trail_dly;
            state_q <= SQ_TRAIL;
          end
        end
        SQ_TRAIL: begin
          if (cnt_q == '0) begin
            cs_on_q <= 1'b0;
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs
);
  localparam int LEN_W = $clog2(DATA_W);

  logic [PRE_W-1:0] prescale_q;
  logic [LEN_W-1:0] len_m1_q;
  logic             cpol_q, cpha_q, lsb_q;
  logic [DLY_W-1:0] lead_q, trail_q;
  logic             cs_dflt_q, cs_act_lvl_q;

  logic accept, start, tick, first_edge, edge_stb, last_edge, run, cs_on, held;

  assign accept   = wr_en && !busy;
  assign start    = accept && (wr_addr == RA_TXWORD);
  assign edge_stb = first_edge || tick;
  assign cs       = cs_on ? cs_act_lvl_q : cs_dflt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale_q   <= '0;
      len_m1_q     <= LEN_W'(7);
      cpol_q       <= 1'b0;
      cpha_q       <= 1'b0;
      lsb_q        <= 1'b0;
      lead_q       <= '0;
      trail_q      <= '0;
      cs_dflt_q    <= 1'b1;
      cs_act_lvl_q <= 1'b0;
    end else if (accept) begin
      case (wr_addr)
        RA_FORMAT: begin
          prescale_q <= wr_data[PRE_W-1:0];
          len_m1_q   <= wr_data[FB_LEN +: LEN_W];
          cpol_q     <= wr_data[FB_CPOL];
          cpha_q     <= wr_data[FB_CPHA];
          lsb_q      <= wr_data[FB_LSB];
        end
        RA_DELAY: begin
          lead_q  <= wr_data[DB_LEAD -: DLY_W];
          trail_q <= wr_data[DB_TRAIL -: DLY_W];
        end
        RA_SELECT: begin
          cs_dflt_q    <= wr_data[SB_IDLE];
          cs_act_lvl_q <= wr_data[SB_ACT];
        end
        default: ;
      endcase
    end
  end

  spi_cs_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .prescale(prescale_q), .tick(tick)
  );

  spi_cs_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_word(wr_data[DATA_W-1:0]),
    .len_m1(len_m1_q), .cpol(cpol_q), .cpha(cpha_q), .lsb_first(lsb_q),
    .edge_stb(edge_stb), .miso(miso), .sclk(sclk), .mosi(mosi),
    .rx_word(rx_data), .last_edge(last_edge)
  );

  spi_cs_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .hold_in(wr_data[TB_HOLD]),
    .lead_dly(lead_q), .trail_dly(trail_q), .last_edge(last_edge),
    .busy(busy), .done(done), .cs_on(cs_on), .first_edge(first_edge),
    .run(run), .held(held)
  );
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk #(
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             sclk,
  input logic             cs,
  input logic             cpol,
  input logic             cs_idle_lvl,
  input logic             cs_act_lvl,
  input logic             held,
  input logic [PRE_W-1:0] prescale
);
  // R1
  cs_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !held) |-> (cs == cs_idle_lvl));

  // R2
  cs_active_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cs == cs_act_lvl));

  // R3
  cs_held_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (cs == cs_act_lvl));

  // R7
  sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));

  // R7
  sclk_moves_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk) && $stable(cpol)) |-> $past(busy));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(prescale) && $stable(cpol) && $stable(cs_act_lvl)));
endmodule

bind spi_cs_master spi_cs_master_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(sclk), .cs(cs),
  .cpol(cpol_q), .cs_idle_lvl(cs_dflt_q), .cs_act_lvl(cs_act_lvl_q),
  .held(held), .prescale(prescale_q)
);

// File: tb/spi_cs_master_test.sv
module spi_cs_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, miso = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        busy, done, sclk, mosi, cs;
  logic [15:0] rx_data;

  int n_chk = 0, n_fail = 0;
  int c_L = 8, c_P = 0, c_pol = 0, c_pha = 0, c_lsb = 0, c_c2t = 0, c_t2c = 0;
  int c_dflt = 1, c_act = 0;
  bit pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cs_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs(cs)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R12-free layout: format 7:0 prescale, 11:8 len-1, 16 cpol, 17 cpha, 18 lsb
  task automatic configure(input int L, P, pol, pha, lsb, c2t, t2c, dflt, act);
    c_L = L; c_P = P; c_pol = pol; c_pha = pha; c_lsb = lsb;
    c_c2t = c2t; c_t2c = t2c; c_dflt = dflt; c_act = act;
    wr(2'd0, 32'(P) | (32'(L-1) << 8) | (32'(pol) << 16) | (32'(pha) << 17) | (32'(lsb) << 18));
    wr(2'd1, (32'(c2t) << 24) | (32'(t2c) << 16));
    wr(2'd2, 32'(dflt) | (32'(act) << 8));
  endtask

  function automatic int pos(input int j);
    return c_lsb ? j : c_L - 1 - j;
  endfunction

  task automatic run_word(input logic [15:0] data, input bit hold, input logic [15:0] rxpat,
                          input int poke_n, input logic [1:0] poke_a, input logic [31:0] poke_d);
    int d_exp = pend ? 0 : c_c2t;
    int k = 0, samples = 0, bad_sp = 0, bad_mo = 0, first_n = -1, last_n = -1;
    int end_n = -1, cs_bad = 0, exp_end;
    logic prev_s;
    logic [15:0] mask = 16'((32'd1 << c_L) - 1);
    @(negedge clk);
    check(sclk == 1'(c_pol), "R7 sclk rest before word", sclk, c_pol);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = {3'b0, hold, 12'b0, data};
    miso = rxpat[pos(0)];
    @(negedge clk);
    wr_en = 1'b0;
    check(cs == 1'(c_act), "R2 cs active after accept", cs, c_act);
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    prev_s = sclk;
    for (int n = 1; n < 3000; n++) begin
      @(negedge clk);
      if (n == poke_n) begin wr_en = 1'b1; wr_addr = poke_a; wr_data = poke_d; end
      else wr_en = 1'b0;
      if (sclk != prev_s) begin
        if (k == 0) first_n = n;
        if (n != d_exp + 1 + k * (c_P + 1)) bad_sp++;
        if (((k % 2) == 0) == (c_pha == 0)) begin
          if (samples < c_L && mosi != data[pos(samples)]) bad_mo++;
          samples++;
          if (samples < c_L) miso = rxpat[pos(samples)];
        end
        last_n = n; k++; prev_s = sclk;
      end
      if (busy) begin
        if (cs != 1'(c_act)) cs_bad++;
      end else begin
        end_n = n;
        break;
      end
    end
    wr_en = 1'b0;
    exp_end = hold ? last_n : last_n + c_t2c + 1;
    check(first_n == d_exp + 1, "R4 first sclk edge cycle", first_n, d_exp + 1);
    check(bad_sp == 0, "R6 sclk edge spacing errors", bad_sp, 0);
    check(k == 2 * c_L, "R7 sclk edge count", k, 2 * c_L);
    check(bad_mo == 0, "R8 R9 mosi bit errors", bad_mo, 0);
    check(rx_data == (rxpat & mask), "R8 R9 rx_data", rx_data, rxpat & mask);
    check(cs_bad == 0, "R2 cs left active level mid-word", cs_bad, 0);
    check(end_n == exp_end, "R5 R10 busy fall cycle", end_n, exp_end);
    check(done == 1'b1, "R10 done at busy fall", done, 1);
    check(cs == 1'(hold ? c_act : c_dflt), hold ? "R3 cs kept active" : "R5 cs released",
          cs, hold ? c_act : c_dflt);
    check(sclk == 1'(c_pol), "R7 sclk rest after word", sclk, c_pol);
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
    pend = hold;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs == 1'b1, "R1 reset cs idle high", cs, 1);
    check(sclk == 1'b0, "R7 reset sclk low", sclk, 0);
    check(busy == 1'b0, "R10 reset busy", busy, 0);
    check(done == 1'b0, "R10 reset done", done, 0);

    for (int li = 0; li < 3; li++)
      for (int p = 0; p < 2; p++)
        for (int pol = 0; pol < 2; pol++)
          for (int pha = 0; pha < 2; pha++)
            for (int lsb = 0; lsb < 2; lsb++)
              for (int dl = 0; dl < 2; dl++)
                for (int tl = 0; tl < 2; tl++) begin
                  int L = (li == 0) ? 1 : (li == 1) ? 5 : 16;
                  configure(L, p * 2, pol, pha, lsb, dl * 3, tl * 2, idx % 2, (idx + 1) % 2);
                  @(negedge clk);
                  check(cs == 1'(c_dflt), "R1 cs idle level", cs, c_dflt);
                  run_word(16'(32'hA5C3 ^ (idx * 32'h1357)), 1'b0,
                           16'(32'h3C96 ^ (idx * 32'h0F1D)), -1, 2'd0, 32'd0);
                  idx++;
                end

    // hold sequence: R3 R4 lead skip after a held word
    configure(4, 1, 0, 0, 0, 3, 2, 1, 0);
    run_word(16'h0009, 1'b1, 16'h0006, -1, 2'd0, 32'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(cs == 1'b0 && !busy, "R3 cs held between words", cs, 0);
    end
    run_word(16'h000A, 1'b1, 16'h0005, -1, 2'd0, 32'd0);
    run_word(16'h0003, 1'b0, 16'h000C, -1, 2'd0, 32'd0);
    @(negedge clk);
    check(cs == 1'b1, "R1 cs idle after held frame", cs, 1);
    run_word(16'h000E, 1'b0, 16'h0001, -1, 2'd0, 32'd0);

    // R11: writes during a busy word are dropped
    configure(8, 1, 1, 1, 0, 2, 1, 0, 1);
    run_word(16'h00B4, 1'b0, 16'h005A, 2, 2'd3, 32'h0000_00FF);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(busy == 1'b0 && sclk == 1'b1, "R11 no word from busy write", busy, 0);
    end
    run_word(16'h0071, 1'b0, 16'h00C8, 3, 2'd1, 32'hFFFF_0000);
    run_word(16'h0042, 1'b0, 16'h0013, 3, 2'd0, 32'h0000_0207);
    run_word(16'h00E1, 1'b0, 16'h009E, 2, 2'd2, 32'h0000_0001);
    run_word(16'h0055, 1'b0, 16'h00AA, -1, 2'd0, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule